// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a simple host request port to a 1M x 16 extended-data-out DRAM whose 12 address pins carry the row first and then the column. The host offers one request at a time with a valid/ready handshake. A request holds a 20-bit word address, a write flag, 16 bits of write data and two byte enables. The controller runs one complete strobe sequence per request. It returns read data with a one-cycle valid pulse.

Each byte lane has its own column strobe. Bits 7:0 follow the lower strobe and bits 15:8 follow the upper strobe, so a masked write falls only on the enabled lanes. Writes use the early form: write enable is already low when the column strobe falls, and the DRAM never drives the data pins during a write.

A free-running timer spreads 4096 refreshes over 64 ms, which comes to one about every 15.6 µs. Each refresh is a CAS-before-RAS cycle, so no row address is needed. A pending refresh is granted only between host accesses. Every strobe phase length is derived from the access times of the 60 ns grade and from the clock frequency parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, all strobes (row, both column, write enable, output enable) are high, the data bus is not driven and the read-valid pulse is low. The host ready signal is high once reset ends.
- R2: When the row strobe falls for an access, the address pins carry host address bits 19:8. When a column strobe falls, the address pins carry bits 7:0 with the upper four pins at zero.
- R3: A read returns the stored word. The read-valid pulse rises on the 7th clock edge after the accepting edge at default timing. Data is taken no earlier than 60 ns after the row strobe fell and no earlier than 15 ns after the column strobe fell.
- R4: A write with enable bit 0 set lowers the lower column strobe and stores bits 7:0. Enable bit 1 does the same for the upper strobe and bits 15:8. A lane whose enable bit is clear keeps its old contents, including when both bits are clear.
- R5: In a write, write enable is already low on the cycle before a column strobe falls, output enable stays high, and the controller drives the data bus.
- R6: Output enable is low only during a read's column phase. At that time both column strobes and the row strobe are low, write enable is high and the controller does not drive the bus.
- R7: A refresh lowers both column strobes at least one cycle before the row strobe falls. Write and output enable stay high, and the row strobe then stays low for at least 7 cycles.
- R8: Refresh cycles start within 20 cycles of every 1562-cycle period at 100 MHz. The total number of refreshes matches the elapsed time to within one.
- R9: A refresh never cuts into an access: the row strobe of an access stays low for exactly 7 cycles. Host ready is low whenever any strobe is low.
- R10: The row strobe stays high for at least 4 cycles between cycles. Successive row strobe falls are at least 11 cycles apart, which covers the 104 ns cycle time.
- R11: Read-valid lasts exactly one cycle and occurs once per read, never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Request offered |
| host_ready | output | 1 | Request can be taken this cycle |
| host_addr | input | 20 | Word address, row in bits 19:8 |
| host_write | input | 1 | 1 for write, 0 for read |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 lower byte |
| host_rvalid | output | 1 | One-cycle read data strobe |
| host_rdata | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data pins |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
Directed accesses at address 0 and at the top address check that the row and column fields are split at bit 8 and never swapped. Masked writes with enables 01, 10 and 00 over a known word show that each lane is steered only by its own strobe. The DRAM model returns poison bytes before the access times have elapsed, so an early capture shows up as a data mismatch. About four hundred random reads and writes draw on a small address pool so that words are rewritten and read back often, and they run back-to-back long enough that refreshes land between accesses. A long idle stretch at the end measures the spacing between refreshes.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int CLK_MHZ       = 100,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 8,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_RC_NS       = 104,
  parameter int T_RP_NS       = 40,
  parameter int REF_ROWS      = 4096,
  parameter int REF_WINDOW_MS = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_valid,
  output logic                   host_ready,
  input  logic [ROW_W+COL_W-1:0] host_addr,
  input  logic                   host_write,
  input  logic [15:0]            host_wdata,
  input  logic [1:0]             host_be,
  output logic                   host_rvalid,
  output logic [15:0]            host_rdata,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_lcas_n,
  output logic                   dram_ucas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [15:0]            dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [15:0]            dram_dq_in
);
  localparam int AW       = ROW_W + COL_W;
  localparam int CLK_PS   = 1000000 / CLK_MHZ;
  localparam int CAS_RAW  = (T_CAC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RCD_RAW  = ((T_RAC_NS - T_CAC_NS) * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CAS_CYC  = CAS_RAW < 1 ? 1 : CAS_RAW;
  localparam int RCD_CYC  = RCD_RAW < 1 ? 1 : RCD_RAW;
  localparam int ACT_CYC  = RCD_CYC + CAS_CYC;
  localparam int RC_CYC   = (T_RC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RP_CYC   = (T_RP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PRE_RAW  = (RC_CYC - ACT_CYC) > RP_CYC ? (RC_CYC - ACT_CYC) : RP_CYC;
  localparam int PRE_CYC  = PRE_RAW < 1 ? 1 : PRE_RAW;
  localparam int REF_CYC  = int'((longint'(REF_WINDOW_MS) * 64'd1000000000 / REF_ROWS) / CLK_PS);
  localparam int CNT_MAX  = ACT_CYC > PRE_CYC ? ACT_CYC : PRE_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam int RW       = $clog2(REF_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CAS, S_PRE, S_CBR, S_RFR} state_t;

  state_t             st;
  logic [CW-1:0]      cnt;
  logic [RW-1:0]      ref_cnt;
  logic               ref_pend;
  logic [COL_W-1:0]   col_q;
  logic               wr_q;
  logic [1:0]         be_q;

  logic ref_tick, ref_grant, accept, cnt_done;

  assign ref_tick   = ref_cnt == RW'(REF_CYC - 1);
  assign ref_grant  = (st == S_IDLE) && ref_pend;
  assign host_ready = (st == S_IDLE) && !ref_pend;
  assign accept     = host_valid && host_ready;
  assign cnt_done   = cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt  <= ref_tick ? '0 : ref_cnt + RW'(1);
      ref_pend <= (ref_pend && !ref_grant) || ref_tick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      be_q        <= 2'b00;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_grant) begin
            dram_addr   <= '0;
            dram_lcas_n <= 1'b0;
            dram_ucas_n <= 1'b0;
            st          <= S_CBR;
          end else if (accept) begin
            dram_addr   <= host_addr[AW-1:COL_W];
            dram_ras_n  <= 1'b0;
            dram_we_n   <= !host_write;
            dram_dq_oe  <= host_write;
            dram_dq_out <= host_wdata;
            col_q       <= host_addr[COL_W-1:0];
            wr_q        <= host_write;
            be_q        <= host_be;
            cnt         <= CW'(RCD_CYC - 1);
            st          <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt_done) begin
            dram_addr   <= ROW_W'(col_q);
            dram_lcas_n <= wr_q ? !be_q[0] : 1'b0;
            dram_ucas_n <= wr_q ? !be_q[1] : 1'b0;
            dram_oe_n   <= wr_q;
            cnt         <= CW'(CAS_CYC - 1);
            st          <= S_CAS;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_CAS: begin
          if (cnt_done) begin
            if (!wr_q) begin
              host_rvalid <= 1'b1;
              host_rdata  <= dram_dq_in;
            end
            dram_ras_n  <= 1'b1;
            dram_lcas_n <= 1'b1;
            dram_ucas_n <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            cnt         <= CW'(PRE_CYC - 1);
            st          <= S_PRE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_CBR: begin
          dram_ras_n <= 1'b0;
          cnt        <= CW'(ACT_CYC - 1);
          st         <= S_RFR;
        end
        S_RFR: begin
          if (cnt_done) begin
            dram_ras_n  <= 1'b1;
            dram_lcas_n <= 1'b1;
            dram_ucas_n <= 1'b1;
            cnt         <= CW'(PRE_CYC - 1);
            st          <= S_PRE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_PRE: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                              hi_cnt <= (CW+1)'(PRE_CYC);
    else if (!dram_ras_n)                    hi_cnt <= '0;
    else if (hi_cnt < (CW+1)'(PRE_CYC))      hi_cnt <= hi_cnt + (CW+1)'(1);
  end

  assert_ras_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= (CW+1)'(PRE_CYC));

  assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |-> ($past(!dram_lcas_n) && $past(!dram_ucas_n)));

  assert_refresh_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |-> (dram_we_n && dram_oe_n));

  assert_we_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> $past(!dram_we_n));

  assert_write_no_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe));

  assert_read_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe && !dram_ras_n));

  assert_col_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && (!dram_lcas_n || !dram_ucas_n)) |-> dram_addr[ROW_W-1:COL_W] == '0);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n || !dram_lcas_n || !dram_ucas_n) |-> !host_ready);

  assert_rvalid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
endmodule

// File: tb/edo_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb_top;
  localparam int ACT  = 7;
  localparam int PRE  = 4;
  localparam int RC   = 11;
  localparam int REFP = 1562;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [19:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = 2'b00;
  logic        host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = 16'hE7E7;

  edo_dram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr),
    .host_write(host_write), .host_wdata(host_wdata), .host_be(host_be),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // DRAM model
  logic [15:0] dmem [int];
  logic [15:0] emem [int];
  logic [19:0] cur_addr = '0, op_addr = '0;
  logic [11:0] row_q = '0;
  time t_ras = 0, t_cas = 0;
  int  cyc = 0, ras_fall_cyc = -100, ras_rise_cyc = -100, last_ref = -1;
  int  ref_count = 0, rd_pulses = 0, n_reads = 0;
  bit  in_ref = 0, p_ras = 1, p_lcas = 1, p_ucas = 1, p_we = 1, p_rv = 0;

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int k);
    return m.exists(k) ? m[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [15:0] w;
    int k;
    bit [1:0] fell;
    cyc++;
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        chk(cyc - ras_fall_cyc >= RC, "R10", "row cycle", cyc - ras_fall_cyc, RC);
        chk(cyc - ras_rise_cyc >= PRE, "R10", "precharge", cyc - ras_rise_cyc, PRE);
        ras_fall_cyc = cyc;
        t_ras = $time - 5;
        if (!dram_lcas_n || !dram_ucas_n) begin
          in_ref = 1;
          chk(!p_lcas && !p_ucas, "R7", "cas before ras", {p_ucas, p_lcas}, 0);
          chk(dram_we_n && dram_oe_n, "R7", "we/oe high", {dram_we_n, dram_oe_n}, 3);
          if (last_ref >= 0)
            chk(cyc - last_ref >= REFP - 20 && cyc - last_ref <= REFP + 20,
                "R8", "refresh spacing", cyc - last_ref, REFP);
          last_ref = cyc;
          ref_count++;
        end else begin
          in_ref = 0;
          op_addr = cur_addr;
          row_q = dram_addr;
          chk(dram_addr == cur_addr[19:8], "R2", "row", dram_addr, cur_addr[19:8]);
        end
      end
      if (!p_ras && dram_ras_n) begin
        ras_rise_cyc = cyc;
        if (in_ref) chk(cyc - ras_fall_cyc >= ACT, "R7", "refresh low", cyc - ras_fall_cyc, ACT);
        else        chk(cyc - ras_fall_cyc == ACT, "R9", "access low", cyc - ras_fall_cyc, ACT);
      end
      fell = {p_ucas && !dram_ucas_n, p_lcas && !dram_lcas_n};
      if (fell != 2'b00 && !dram_ras_n) begin
        t_cas = $time - 5;
        chk(dram_addr == {4'h0, op_addr[7:0]}, "R2", "column", dram_addr, {4'h0, op_addr[7:0]});
        if (!dram_we_n) begin
          chk(!p_we, "R5", "we before cas", p_we, 0);
          chk(dram_oe_n && dram_dq_oe, "R5", "oe high, bus driven", {dram_oe_n, dram_dq_oe}, 3);
          k = int'({row_q, dram_addr[7:0]});
          w = rd_word(dmem, k);
          if (fell[0]) w[7:0]  = dram_dq_out[7:0];
          if (fell[1]) w[15:8] = dram_dq_out[15:8];
          dmem[k] = w;
        end
      end
      if (!dram_oe_n)
        chk(dram_we_n && !dram_dq_oe && !dram_lcas_n && !dram_ucas_n && !dram_ras_n,
            "R6", "read strobes", {dram_we_n, dram_dq_oe, dram_lcas_n, dram_ucas_n}, 8);
      if (!dram_ras_n || !dram_lcas_n || !dram_ucas_n)
        chk(!host_ready, "R9", "ready while busy", host_ready, 0);
      if (host_rvalid) begin
        rd_pulses++;
        chk(!p_rv, "R11", "rvalid width", p_rv, 0);
      end
      dram_dq_in = 16'hE7E7;
      if (!dram_ras_n && !dram_oe_n && ($time + 5 - t_ras >= 60) && ($time + 5 - t_cas >= 15)) begin
        w = rd_word(dmem, int'({row_q, dram_addr[7:0]}));
        if (!dram_lcas_n) dram_dq_in[7:0]  = w[7:0];
        if (!dram_ucas_n) dram_dq_in[15:8] = w[15:8];
      end
    end
    p_ras = dram_ras_n; p_lcas = dram_lcas_n; p_ucas = dram_ucas_n;
    p_we = dram_we_n; p_rv = host_rvalid;
  end

  task automatic host_op(input logic [19:0] a, input bit w, input logic [15:0] d,
                         input logic [1:0] b);
    logic [15:0] e;
    int k;
    @(negedge clk);
    cur_addr = a;
    host_addr = a; host_write = w; host_wdata = d; host_be = b; host_valid = 1'b1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    if (w) begin
      e = rd_word(emem, int'(a));
      if (b[0]) e[7:0]  = d[7:0];
      if (b[1]) e[15:8] = d[15:8];
      emem[int'(a)] = e;
    end else begin
      n_reads++;
      e = rd_word(emem, int'(a));
      k = 1;
      while (!host_rvalid && k < 40) begin @(negedge clk); k++; end
      chk(host_rvalid == 1'b1, "R3", "rvalid seen", host_rvalid, 1);
      chk(k == 8, "R3", "read latency", k, 8);
      chk(host_rdata == e, "R3", "read data", host_rdata, e);
    end
  endtask

  logic [19:0] pool [16];

  initial begin
    void'($urandom(32'h1ED05EED));
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n &&
        !dram_dq_oe && !host_rvalid, "R1", "strobes in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready == 1'b1, "R1", "ready after reset", host_ready, 1);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && !dram_dq_oe, "R1", "idle strobes", 0, 0);

    host_op(20'h00000, 1, 16'hABCD, 2'b11);
    host_op(20'h00000, 0, 16'h0000, 2'b11);
    host_op(20'hFFFFF, 1, 16'h1234, 2'b11);
    host_op(20'hFFFFF, 0, 16'h0000, 2'b11);
    host_op(20'h00100, 1, 16'h5A5A, 2'b11);
    host_op(20'h00001, 1, 16'hC3C3, 2'b11);
    host_op(20'h00100, 0, 16'h0000, 2'b11);
    host_op(20'h00001, 0, 16'h0000, 2'b11);
    host_op(20'hFFFFF, 1, 16'h9955, 2'b01);  // R4 lower lane only
    host_op(20'hFFFFF, 0, 16'h0000, 2'b11);
    host_op(20'hFFFFF, 1, 16'h77EE, 2'b10);  // R4 upper lane only
    host_op(20'hFFFFF, 0, 16'h0000, 2'b11);
    host_op(20'hFFFFF, 1, 16'h0000, 2'b00);  // R4 no lane
    host_op(20'hFFFFF, 0, 16'h0000, 2'b11);

    pool[0] = 20'h00000; pool[1] = 20'hFFFFF;
    for (int i = 2; i < 16; i++) pool[i] = 20'($urandom);
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      a = ($urandom_range(0, 3) == 0) ? 20'($urandom) : pool[$urandom_range(0, 15)];
      host_op(a, bit'($urandom_range(0, 1)), 16'($urandom), 2'($urandom));
    end
    for (int i = 0; i < 16; i++) host_op(pool[i], 0, 16'h0000, 2'b11);

    repeat (8000) @(negedge clk);
    chk(rd_pulses == n_reads, "R11", "one pulse per read", rd_pulses, n_reads);
    chk(ref_count >= cyc / REFP - 2 && ref_count <= cyc / REFP + 1, "R8", "refresh total",
        ref_count, cyc / REFP);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule